// File: doc/BRIEF.md
# Round-Robin Packet Read Selector

This block lets a DMA engine empty several sample buffers through a single memory-mapped read location. Each buffer raises a ready input once it holds a complete packet. The selector picks one ready buffer, opens a burst on it and raises a DMA request. Every bus read that hits the shared location is then routed to that buffer: its read enable is pulsed and its data is placed on the read bus, all in the same cycle.

After a fixed number of reads (the packet length), the burst closes and the request drops for one cycle. The search for the next buffer then starts at the channel after the one just served and wraps around. Buffers that are not ready are passed over. If the shared location is read while no burst is open, the read returns zero and a sticky underrun flag is set.

Top module: `rr_pkt_rdsel`

## Requirements
- R1: While a burst is open, a read access (`bus_rd` and `bus_hit` both high) pulses the read enable of the selected channel only, in the same cycle. No enable is ever asserted outside an open burst.
- R2: During a read access in an open burst, `bus_rdata` carries the selected channel's data word, where channel k occupies bits [k*DW +: DW] of `ch_data`. In every other cycle `bus_rdata` is zero.
- R3: After reset the search pointer is channel 0. The first burst goes to the lowest-indexed ready channel, and `dma_req` rises on the clock edge after the ready input is seen.
- R4: A burst closes on its PKT_LEN-th read access. `dma_req` is low in the cycle that follows that read.
- R5: After a burst on channel c, the search for the next burst starts at channel c+1 and wraps from N_CH-1 to 0.
- R6: Channels whose ready input is low are skipped in rotation order, and a burst is opened only on a ready channel.
- R7: While no channel is ready and no burst is open, `dma_req` stays low and no read enable is asserted.
- R8: A read access while no burst is open returns zero, asserts no read enable, and sets `underrun` on the next edge. `underrun` then stays high until reset.
- R9: `bus_rd` without `bus_hit`, or `bus_hit` without `bus_rd`, has no effect. No enable is pulsed, the data bus stays zero and the burst count does not advance.
- R10: Dropping the selected channel's ready input in the middle of a burst does not end the burst. It still closes only after PKT_LEN accesses.
- R11: During and right after reset, `dma_req`, every `ch_rden` bit and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Bus read strobe |
| bus_hit | input | 1 | Bus address matches the shared location |
| bus_rdata | output | DW | Read data returned to the bus |
| ch_ready | input | N_CH | Per-channel packet-available flags |
| ch_data | input | N_CH*DW | Per-channel head-of-buffer data, flattened |
| ch_rden | output | N_CH | Per-channel read enables |
| dma_req | output | 1 | DMA request, high while a burst is open |
| underrun | output | 1 | Sticky flag: the location was read with no burst open |

## Verification
The rotation is driven with several ready patterns:
- A single lone ready channel shows that the first grant starts from channel 0.
- All channels ready shows strict rotation and the wrap from the top channel to channel 0.
- A sparse pattern shows skipping.
- An all-clear pattern shows that the request stays silent.

Each channel returns a word made of its index and a running count. This separates a wrong channel from a lost or doubled read. Stray strobes without an address match, a ready drop mid-burst, and a read with no open burst separate burst-length counting from ready tracking and from the underrun path.

// File: rtl/rr_sel_pkg.sv
package rr_sel_pkg;

   // index width for a channel count, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // burst counter width for a packet length
   function automatic int cnt_w(input int len);
      return (len > 1) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N_CH = 4,
   parameter int IW   = 2
) (
   input  logic [N_CH-1:0] req,
   input  logic [IW-1:0]   start,
   output logic            found,
   output logic [IW-1:0]   idx
);

   int unsigned pos;

   always_comb begin
      found = 1'b0;
      idx   = start;
      pos   = 0;
      for (int i = 0; i < N_CH; i++) begin
         pos = (int'(start) + i) % N_CH;
         if (!found && req[pos]) begin
            found = 1'b1;
            idx   = IW'(pos);
         end
      end
   end

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
   parameter int PKT_LEN = 8,
   parameter int CW      = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic adv,
   output logic last
);

   generate
      if (PKT_LEN == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LAST_VAL = CW'(PKT_LEN - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (restart)
               cnt <= '0;
            else if (adv)
               cnt <= (cnt == LAST_VAL) ? '0 : cnt + 1'b1;
         end

         assign last = (cnt == LAST_VAL);
      end
   endgenerate

endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
   parameter int N_CH = 4,
   parameter int DW   = 16,
   parameter int IW   = 2
) (
   input  logic [N_CH*DW-1:0] din,
   input  logic [IW-1:0]      sel,
   input  logic               en,
   output logic [DW-1:0]      dout
);

   logic [DW-1:0] lane [N_CH];

   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_lane
         assign lane[k] = din[k*DW +: DW];
      end
   endgenerate

   always_comb begin
      dout = '0;
      for (int k = 0; k < N_CH; k++)
         if (en && sel == IW'(k))
            dout = lane[k];
   end

endmodule

// File: rtl/rr_pkt_rdsel.sv
module rr_pkt_rdsel
   import rr_sel_pkg::*;
#(
   parameter int N_CH    = 4,
   parameter int DW      = 16,
   parameter int PKT_LEN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd,
   input  logic               bus_hit,
   output logic [DW-1:0]      bus_rdata,
   input  logic [N_CH-1:0]    ch_ready,
   input  logic [N_CH*DW-1:0] ch_data,
   output logic [N_CH-1:0]    ch_rden,
   output logic               dma_req,
   output logic               underrun
);

   localparam int IW = idx_w(N_CH);
   localparam int CW = cnt_w(PKT_LEN);
   localparam logic [IW-1:0] TOP_IDX = IW'(N_CH - 1);

   generate
      if (N_CH < 2) begin : g_bad_nch
         $error("rr_pkt_rdsel: N_CH must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rr_pkt_rdsel: DW must be at least 1");
      end
      if (PKT_LEN < 1) begin : g_bad_len
         $error("rr_pkt_rdsel: PKT_LEN must be at least 1");
      end
   endgenerate

   logic          active;
   logic [IW-1:0] cur;
   logic [IW-1:0] nxt_base;
   logic          found;
   logic [IW-1:0] pick;
   logic          access;
   logic          hit_rd;
   logic          last;
   logic          opening;

   assign access  = bus_rd & bus_hit;
   assign hit_rd  = active & access;
   assign opening = ~active & found;

   rr_pick #(.N_CH(N_CH), .IW(IW)) u_pick (
      .req   (ch_ready),
      .start (nxt_base),
      .found (found),
      .idx   (pick)
   );

   burst_ctr #(.PKT_LEN(PKT_LEN), .CW(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (opening),
      .adv     (hit_rd),
      .last    (last)
   );

   rd_mux #(.N_CH(N_CH), .DW(DW), .IW(IW)) u_mux (
      .din  (ch_data),
      .sel  (cur),
      .en   (hit_rd),
      .dout (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur      <= '0;
         nxt_base <= '0;
      end else if (opening) begin
         active <= 1'b1;
         cur    <= pick;
      end else if (hit_rd && last) begin
         active   <= 1'b0;
         nxt_base <= (cur == TOP_IDX) ? '0 : cur + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         underrun <= 1'b0;
      else if (access && !active)
         underrun <= 1'b1;
   end

   generate
      for (genvar k = 0; k < N_CH; k++) begin : g_en
         assign ch_rden[k] = hit_rd && (cur == IW'(k));
      end
   endgenerate

   assign dma_req = active;

   // R1: never more than one enable, and only inside an open burst
   p_rden_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_rden));
   p_rden_in_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_rden) |-> dma_req);
   // R2: the data bus is quiet outside a routed read
   p_rdata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ch_rden) |-> (bus_rdata == '0));
   // R4: the request drops after the closing read
   p_gap_after_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_rd && last) |=> !dma_req);
   // R6: the picker only grants a ready channel
   p_grant_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      opening |-> ch_ready[pick]);
   // R7: nothing ready keeps the request low
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_req && ch_ready == '0) |=> !dma_req);
   // R8: the underrun flag is sticky
   p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
   // R9: a strobe without address match enables nothing
   p_stray_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_hit) |-> (ch_rden == '0));

endmodule

// File: tb/test_rr_pkt_rdsel.sv
`timescale 1ns/1ps
module test_rr_pkt_rdsel;

   localparam int N  = 4;
   localparam int DW = 16;
   localparam int PL = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_rd = 1'b0;
   logic            bus_hit = 1'b0;
   logic [DW-1:0]   bus_rdata;
   logic [N-1:0]    ch_ready = '0;
   logic [N*DW-1:0] ch_data;
   logic [N-1:0]    ch_rden;
   logic            dma_req;
   logic            underrun;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [7:0] seq [N];
   logic [7:0] exp_seq [N];
   int         q_ch[$];
   logic [DW-1:0] q_dat[$];

   always #2.5 clk = ~clk;

   rr_pkt_rdsel #(.N_CH(N), .DW(DW), .PKT_LEN(PL)) i_rr_pkt_rdsel (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_hit(bus_hit),
      .bus_rdata(bus_rdata), .ch_ready(ch_ready), .ch_data(ch_data),
      .ch_rden(ch_rden), .dma_req(dma_req), .underrun(underrun));

   // buffer models: word = {channel, running count}
   always_ff @(posedge clk) begin
      for (int k = 0; k < N; k++)
         if (!rst_n) seq[k] <= '0;
         else if (ch_rden[k]) seq[k] <= seq[k] + 1'b1;
   end
   always_comb begin
      for (int k = 0; k < N; k++)
         ch_data[k*DW +: DW] = {8'(k), seq[k]};
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   // scoreboard monitor
   always begin
      @(negedge clk);
      #1;
      if (rst_n && bus_rd && bus_hit) begin
         if (q_ch.size() == 0) begin
            chk(0, "R1 unexpected read", 0, 1);
         end else begin
            int ch;
            logic [DW-1:0] d;
            ch = q_ch.pop_front();
            d  = q_dat.pop_front();
            if (ch < 0) begin
               chk(ch_rden == '0, "R8 enable on underrun read", ch_rden, 0);
               chk(bus_rdata == '0, "R8 data on underrun read", bus_rdata, 0);
            end else begin
               chk(ch_rden == N'(1 << ch), "R1 routed enable", ch_rden, 1 << ch);
               chk(bus_rdata == d, "R2 routed data", bus_rdata, d);
            end
         end
      end
   end

   task automatic idle();
      bus_rd = 0;
      bus_hit = 0;
   endtask

   task automatic wait_req(input string req);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         idle();
         #1;
         if (dma_req) break;
      end
      chk(dma_req, req, dma_req, 1);
   endtask

   task automatic burst(input int ch, input int drop_at);
      for (int i = 0; i < PL; i++) begin
         @(negedge clk);
         if (i == drop_at) ch_ready = '0;
         bus_rd = 1;
         bus_hit = 1;
         q_ch.push_back(ch);
         q_dat.push_back({8'(ch), exp_seq[ch]});
         exp_seq[ch]++;
      end
      @(negedge clk);
      idle();
      #1;
      chk(!dma_req, "R4 gap after burst", dma_req, 0);
   endtask

   initial begin
      for (int k = 0; k < N; k++) exp_seq[k] = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(!dma_req && ch_rden == '0 && !underrun, "R11 reset state",
          {dma_req, underrun, ch_rden}, 0);
      @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      #1;
      chk(!dma_req, "R7 nothing ready", dma_req, 0);

      // R3: lone ready channel 2, request one edge later
      @(negedge clk);
      ch_ready = 4'b0100;
      @(negedge clk);
      #1;
      chk(dma_req, "R3 request after ready", dma_req, 1);

      // R9: stray strobes
      @(negedge clk);
      bus_rd = 1; bus_hit = 0;
      #1;
      chk(ch_rden == '0 && bus_rdata == '0, "R9 strobe without match",
          {ch_rden, bus_rdata}, 0);
      @(negedge clk);
      bus_rd = 0; bus_hit = 1;
      #1;
      chk(ch_rden == '0 && bus_rdata == '0, "R9 match without strobe",
          {ch_rden, bus_rdata}, 0);
      burst(2, -1);

      // R5: all ready, rotation 3 -> 0 -> 1 with wrap
      ch_ready = 4'b1111;
      wait_req("R5 grant after ch2");
      burst(3, -1);
      wait_req("R5 grant wrap");
      burst(0, -1);
      wait_req("R5 grant ch1");
      burst(1, -1);

      // R6: base is 2, only 3 and 0 ready
      ch_ready = 4'b1001;
      wait_req("R6 grant skip");
      burst(3, -1);
      wait_req("R6 grant ch0");
      burst(0, -1);

      // R10: ready drops mid-burst on channel 2
      ch_ready = 4'b0100;
      wait_req("R10 grant ch2");
      burst(2, 2);

      // R7 then R8
      repeat (3) @(negedge clk);
      #1;
      chk(!dma_req && ch_rden == '0, "R7 quiet with no ready", dma_req, 0);
      chk(!underrun, "R8 flag clear before misuse", underrun, 0);
      @(negedge clk);
      bus_rd = 1; bus_hit = 1;
      q_ch.push_back(-1);
      q_dat.push_back('0);
      @(negedge clk);
      idle();
      #1;
      chk(underrun, "R8 underrun set", underrun, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(underrun, "R8 underrun sticky", underrun, 1);
      chk(q_ch.size() == 0, "R1 all expected reads seen", q_ch.size(), 0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

endmodule